// File: doc/BRIEF.md
# Fiducial Watchdog and Status Logic

This block watches a fiducial strobe. The strobe can come from an external timing source or from a fiducial that software injects. The block records whether each fiducial arrived, and it raises a missing-fiducial flag when the gap between fiducials grows too long. A timeout counter runs on the reference clock. Every fiducial restarts it. When the counter reaches the limit, the missing flag is raised. A static strap input picks one of two window lengths, 0x80000 or 0x100000 cycles by default. After flagging, the counter saturates, so a single gap raises the flag only once.

Two sticky flags hold the results: a detected flag and a missing flag. Reading the status byte clears both of them, and so does a dedicated clear strobe. If a new event arrives in the same cycle as a clear, the new event wins.

The status byte also reports four control bits: interrupt enable, output enable, sequencer enable and local clock select. Host set and clear strobes change these bits. The block has three further outputs:
- An interrupt request, asserted while the missing flag is set and interrupts are enabled.
- A test response that mirrors the missing flag.
- A front-panel detect LED output, stretched to a parameter length that defaults to about 3 ms at 125 MHz.

Top module: `fid_watchdog`

## Requirements
- R1: After a synchronous reset, the following are all 0: the status byte, the control bits, both flags, `led_o`, `irq_o` and `test_q_o`.
- R2: With `window_sel_i` = 0, the missing flag (status bit 7) sets at the clock edge that falls exactly SHORT_CYCLES edges after the last fiducial edge (or after reset release). One edge earlier, it is still clear.
- R3: With `window_sel_i` = 1, the same timing holds with LONG_CYCLES in place of SHORT_CYCLES.
- R4: A fiducial on `fid_ext_i` or on `fid_inject_i` has three effects at its clock edge: it sets the detected flag (status bit 6), it restarts the timeout, and it retriggers the LED. The two sources behave identically.
- R5: The missing flag is raised once per gap. After it is cleared, it does not set again until a new fiducial arrives and a new full window elapses.
- R6: `status_o` shows the current status combinationally. A cycle with `status_rd_i` high clears both flags at that edge.
- R7: A cycle with `flag_clr_i` high clears both flags at that edge.
- R8: A flag whose set event occurs in the same cycle as a read or clear stays set.
- R9: `irq_o` is high exactly when the missing flag is set and the interrupt-enable bit (status bit 0) is 1.
- R10: `test_q_o` equals the missing flag.
- R11: `led_o` is high for exactly STRETCH_CYCLES cycles after a fiducial edge. A fiducial during that time restarts the full length.
- R12: The status byte has this layout:
  - bit0: interrupt enable
  - bit1: output enable
  - bit2: sequencer enable
  - bit3: local clock select
  - bits 4 and 5: always 0
  - bit6: detected
  - bit7: missing

  The control bit i is cleared by `ctrl_clr_i[i]` and set by `ctrl_set_i[i]`. When both are high in the same cycle, set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| window_sel_i | input | 1 | Static strap: 0 selects the short window, 1 selects the long window |
| fid_ext_i | input | 1 | External fiducial strobe, one cycle per fiducial |
| fid_inject_i | input | 1 | Software-injected fiducial strobe |
| ctrl_set_i | input | 4 | Set strobes for the control bits |
| ctrl_clr_i | input | 4 | Clear strobes for the control bits |
| status_rd_i | input | 1 | Status read strobe; clears both flags |
| flag_clr_i | input | 1 | Explicit flag clear command |
| status_o | output | 8 | Status byte |
| test_q_o | output | 1 | Test response, equal to the missing flag |
| irq_o | output | 1 | Interrupt request |
| led_o | output | 1 | Stretched detect LED drive |

## Verification
The assertions assume three things about the inputs:
- Fiducial strobes are single-cycle pulses separated by more than one cycle.
- The strap is held constant, except while a fresh fiducial restarts the window.
- The window parameters are larger than one.

The stimulus keeps to these assumptions. It pulses each fiducial for one cycle and changes `window_sel_i` only just before it sends a fiducial. It drives read and clear strobes for single cycles, sometimes in the same cycle as an event, so that the precedence rule is exercised.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef struct packed {
        logic lclk_sel;
        logic seq_en;
        logic out_en;
        logic irq_en;
    } ctrl_t;

    typedef struct packed {
        logic missing;
        logic detected;
    } flags_t;

    function automatic logic [7:0] pack_status(ctrl_t c, flags_t f);
        return {f.missing, f.detected, 2'b00, c};
    endfunction

endpackage

// File: rtl/fwd_timeout.sv
module fwd_timeout #(
    parameter int unsigned SHORT_CYCLES = 32'h80000,
    parameter int unsigned LONG_CYCLES  = 32'h100000
) (
    input  logic clk,
    input  logic rst,
    input  logic window_sel_i,
    input  logic fid_i,
    output logic miss_evt_o
);
    localparam int CW = $clog2(LONG_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit = window_sel_i ? CW'(LONG_CYCLES) : CW'(SHORT_CYCLES);

    always_ff @(posedge clk) begin
        if (rst || fid_i)
            cnt_q <= '0;
        else if (cnt_q < limit)
            cnt_q <= cnt_q + 1'b1;
    end

    assign miss_evt_o = !fid_i && (cnt_q == limit - 1'b1);

    // R5
    miss_once_chk: assert property (@(posedge clk) disable iff (rst)
        miss_evt_o |=> !miss_evt_o);

    // R2
    miss_not_after_fid_chk: assert property (@(posedge clk) disable iff (rst)
        fid_i |=> !miss_evt_o);

endmodule

// File: rtl/fwd_stretch.sv
module fwd_stretch #(
    parameter int unsigned STRETCH_CYCLES = 375000
) (
    input  logic clk,
    input  logic rst,
    input  logic fid_i,
    output logic led_o
);
    localparam int SW = $clog2(STRETCH_CYCLES + 1);

    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (fid_i)
            cnt_q <= SW'(STRETCH_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign led_o = (cnt_q != '0);

    // R11
    led_on_after_fid_chk: assert property (@(posedge clk) disable iff (rst)
        fid_i |=> led_o);

endmodule

// File: rtl/fwd_flags.sv
module fwd_flags
    import fwd_pkg::*;
#(
    parameter int CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              det_evt_i,
    input  logic              miss_evt_i,
    input  logic              clear_i,
    input  logic [CTRL_W-1:0] ctrl_set_i,
    input  logic [CTRL_W-1:0] ctrl_clr_i,
    output flags_t            flags_o,
    output ctrl_t             ctrl_o
);
    flags_t flags_q;
    ctrl_t  ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            ctrl_q  <= '0;
        end else begin
            flags_q.detected <= det_evt_i  | (flags_q.detected & ~clear_i);
            flags_q.missing  <= miss_evt_i | (flags_q.missing  & ~clear_i);
            ctrl_q           <= (ctrl_q & ~ctrl_clr_i) | ctrl_set_i;
        end
    end

    assign flags_o = flags_q;
    assign ctrl_o  = ctrl_q;

    // R8
    miss_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        miss_evt_i |=> flags_q.missing);

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_i && !miss_evt_i && !det_evt_i) |=> (flags_q == '0));

endmodule

// File: rtl/fid_watchdog.sv
module fid_watchdog
    import fwd_pkg::*;
#(
    parameter int unsigned SHORT_CYCLES   = 32'h80000,
    parameter int unsigned LONG_CYCLES    = 32'h100000,
    parameter int unsigned STRETCH_CYCLES = 375000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       window_sel_i,
    input  logic       fid_ext_i,
    input  logic       fid_inject_i,
    input  logic [3:0] ctrl_set_i,
    input  logic [3:0] ctrl_clr_i,
    input  logic       status_rd_i,
    input  logic       flag_clr_i,
    output logic [7:0] status_o,
    output logic       test_q_o,
    output logic       irq_o,
    output logic       led_o
);
    logic   fid;
    logic   miss_evt;
    flags_t flags;
    ctrl_t  ctrl;

    assign fid = fid_ext_i | fid_inject_i;

    fwd_timeout #(
        .SHORT_CYCLES(SHORT_CYCLES),
        .LONG_CYCLES (LONG_CYCLES)
    ) u_timeout (
        .clk         (clk),
        .rst         (rst),
        .window_sel_i(window_sel_i),
        .fid_i       (fid),
        .miss_evt_o  (miss_evt)
    );

    fwd_stretch #(
        .STRETCH_CYCLES(STRETCH_CYCLES)
    ) u_stretch (
        .clk  (clk),
        .rst  (rst),
        .fid_i(fid),
        .led_o(led_o)
    );

    fwd_flags #(
        .CTRL_W(4)
    ) u_flags (
        .clk       (clk),
        .rst       (rst),
        .det_evt_i (fid),
        .miss_evt_i(miss_evt),
        .clear_i   (status_rd_i | flag_clr_i),
        .ctrl_set_i(ctrl_set_i),
        .ctrl_clr_i(ctrl_clr_i),
        .flags_o   (flags),
        .ctrl_o    (ctrl)
    );

    assign status_o = pack_status(ctrl, flags);
    assign test_q_o = flags.missing;
    assign irq_o    = flags.missing & ctrl.irq_en;

    // R9
    irq_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (status_o[7] && status_o[0]));

    // R4
    fid_sets_detect_chk: assert property (@(posedge clk) disable iff (rst)
        fid |=> status_o[6]);

endmodule

// File: tb/fid_watchdog_tb.sv
`timescale 1ns/1ps
module fid_watchdog_tb;
    localparam int unsigned SHORT   = 40;
    localparam int unsigned LONG    = 80;
    localparam int unsigned STRETCH = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       window_sel_i = 1'b0;
    logic       fid_ext_i = 1'b0;
    logic       fid_inject_i = 1'b0;
    logic [3:0] ctrl_set_i = '0;
    logic [3:0] ctrl_clr_i = '0;
    logic       status_rd_i = 1'b0;
    logic       flag_clr_i = 1'b0;
    logic [7:0] status_o;
    logic       test_q_o, irq_o, led_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    fid_watchdog #(
        .SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG), .STRETCH_CYCLES(STRETCH)
    ) u_dut (
        .clk(clk), .rst(rst), .window_sel_i(window_sel_i),
        .fid_ext_i(fid_ext_i), .fid_inject_i(fid_inject_i),
        .ctrl_set_i(ctrl_set_i), .ctrl_clr_i(ctrl_clr_i),
        .status_rd_i(status_rd_i), .flag_clr_i(flag_clr_i),
        .status_o(status_o), .test_q_o(test_q_o), .irq_o(irq_o), .led_o(led_o)
    );

    // control vectors: {set, clr, expected control bits}
    localparam int NV = 6;
    localparam logic [11:0] VEC [NV] = '{
        {4'b0001, 4'b0000, 4'b0001},
        {4'b0110, 4'b0000, 4'b0111},
        {4'b1000, 4'b0001, 4'b1110},
        {4'b0000, 4'b0110, 4'b1000},
        {4'b0010, 4'b0010, 4'b1010},
        {4'b0000, 4'b1111, 4'b0000}
    };

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_ext();
        fid_ext_i = 1'b1; tick(); fid_ext_i = 1'b0;
    endtask

    task automatic pulse_inj();
        fid_inject_i = 1'b1; tick(); fid_inject_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(3);
        // R1 reset state
        check("R1 status", status_o, 8'h00);
        check("R1 led", led_o, 1'b0);
        check("R1 irq", irq_o, 1'b0);
        check("R1 testq", test_q_o, 1'b0);
        rst = 1'b0;

        // R12 control vectors
        for (int i = 0; i < NV; i++) begin
            ctrl_set_i = VEC[i][11:8];
            ctrl_clr_i = VEC[i][7:4];
            tick();
            ctrl_set_i = '0; ctrl_clr_i = '0;
            check("R12 ctrl", status_o[3:0], VEC[i][3:0]);
            check("R12 zero bits", status_o[5:4], 2'b00);
        end

        // clear any flags from the startup gap
        flag_clr_i = 1'b1; tick(); flag_clr_i = 1'b0;

        // R4 external fiducial, R11 stretch, R2 short window
        pulse_ext();
        check("R4 detected", status_o[6], 1'b1);
        check("R11 led on", led_o, 1'b1);
        tick(STRETCH - 1);
        check("R11 led last", led_o, 1'b1);
        tick();
        check("R11 led off", led_o, 1'b0);
        tick(SHORT - 1 - STRETCH);
        check("R2 not yet", status_o[7], 1'b0);
        tick();
        check("R2 missing", status_o[7], 1'b1);
        check("R10 testq", test_q_o, 1'b1);
        check("R9 irq disabled", irq_o, 1'b0);

        // R6 read clears
        status_rd_i = 1'b1;
        #1;
        check("R6 read value", status_o, 8'hC0);
        tick(); status_rd_i = 1'b0;
        check("R6 cleared", status_o[7:6], 2'b00);
        check("R10 testq clear", test_q_o, 1'b0);

        // R5 no second raise in the same gap
        tick(2 * LONG);
        check("R5 once per gap", status_o[7], 1'b0);

        // R9 with injected fiducial (R4)
        ctrl_set_i = 4'b0001; tick(); ctrl_set_i = '0;
        pulse_inj();
        check("R4 inject detected", status_o[6], 1'b1);
        check("R4 inject led", led_o, 1'b1);
        tick(SHORT - 1);
        check("R9 irq before", irq_o, 1'b0);
        tick();
        check("R9 irq raised", irq_o, 1'b1);

        // R7 clear command
        flag_clr_i = 1'b1; tick(); flag_clr_i = 1'b0;
        check("R7 flags", status_o[7:6], 2'b00);
        check("R9 irq cleared", irq_o, 1'b0);

        // R3 long window
        window_sel_i = 1'b1;
        pulse_ext();
        tick(LONG - 1);
        check("R3 not yet", status_o[7], 1'b0);
        tick();
        check("R3 missing", status_o[7], 1'b1);

        // R8 fiducial with clear: detected stays, missing clears
        fid_ext_i = 1'b1; flag_clr_i = 1'b1; tick();
        fid_ext_i = 1'b0; flag_clr_i = 1'b0;
        check("R8 detected kept", status_o[7:6], 2'b01);
        // R8 missing event with read in the same cycle
        tick(LONG - 1);
        status_rd_i = 1'b1; tick(); status_rd_i = 1'b0;
        check("R8 missing kept", status_o[7:6], 2'b10);

        // R11 retrigger
        pulse_ext();
        tick(5);
        pulse_inj();
        tick(STRETCH - 1);
        check("R11 retrigger on", led_o, 1'b1);
        tick();
        check("R11 retrigger off", led_o, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule